// File: doc/BRIEF.md
# Parallel 8080-Style Panel Write Engine

This block sends one frame of pixel words to a panel that has an 8080-style CPU bus. For every word it drives an active-low chip select, an active-low write strobe and a data bus. Four programmable phase lengths shape each word: chip-select lead, write lead, strobe-low time and data hold. Software programs the phase lengths, the frame geometry and an interrupt mask through a small write-only register port. A frame starts only when software issues a trigger command. The block never generates frames by itself.

Pixel words arrive on a valid/ready stream. The engine raises `pix_ready` only while a frame is running and the bus is idle between two words. A word is taken on a clock edge where `pix_valid` and `pix_ready` are both high. While `pix_valid` is low, the bus waits with chip select released, and no word is lost or repeated. A source may hold `pix_valid` high for as long as it likes. The engine sets the pace and applies back-pressure by keeping `pix_ready` low for the whole time a word is on the bus.

When the last word of a frame leaves the bus, a sticky done flag is set. Writing 1 to the flag clears it. The interrupt output is the flag gated by an enable bit. A trigger that arrives while a frame is running is dropped, because a second start can upset the panel. The lock ends when the frame ends, whether or not the interrupt is enabled.

Top module: `i80_panel_writer`

## Requirements
- R1: After reset, `lcd_cs_n` and `lcd_wr_n` are high, and `frame_irq` and `pix_ready` are low.
- R2: Register 0 holds the timing fields: chip-select lead in bits 19:16, write lead in bits 15:12, strobe-low time in bits 11:8, hold in bits 7:4, and the interface enable in bit 0. For each word, `lcd_cs_n` is low for exactly chip-select lead plus write lead cycles before `lcd_wr_n` falls.
- R3: `lcd_wr_n` stays low for the strobe-low time in cycles. A programmed value of 0 acts as 1.
- R4: After `lcd_wr_n` rises, `lcd_cs_n` stays low for the hold count, then goes high. `lcd_data` is constant while `lcd_cs_n` is low and carries the accepted words in the order they were accepted.
- R5: `pix_ready` is high only while a frame is running and no word is on the bus. A stalled source leaves `lcd_cs_n` high.
- R6: A write to register 1 starts a frame only if bits 0 (I80 mode) and 1 (trigger command) are both 1 and the interface enable is set. Any other trigger write has no effect.
- R7: The frame length in words is width (register 2, bits 15:0) times height (register 2, bits 31:16). If either is zero, the frame completes without any bus activity.
- R8: A trigger accepted while a frame is running is ignored. The frame length is not changed and no extra frame follows.
- R9: `frame_irq` equals the done flag ANDed with register 3 bit 0. The flag becomes visible one cycle after `lcd_cs_n` rises at the end of the last word.
- R10: Writing 1 to register 4 bit 0 clears the flag, and the change shows on the cycle after the write edge. Writing 0 to that bit leaves the flag set.
- R11: The trigger lock ends at frame end even when the interrupt is masked. A later trigger is then accepted.
- R12: Without a trigger there is no bus activity. After a frame ends, the bus stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| pix_valid | input | 1 | Pixel word valid |
| pix_data | input | DW | Pixel word |
| pix_ready | output | 1 | Engine can take a word |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_wr_n | output | 1 | Panel write strobe, active low |
| lcd_data | output | DW | Panel data bus |
| frame_irq | output | 1 | Frame-done interrupt |

## Verification
Phase timing is due relative to the accepted word. `lcd_cs_n` falls right after the handshake edge, and the bench counts low cycles at each falling clock edge to measure the lead, strobe and hold lengths. The trigger write edge registers a start pulse, the running state follows one edge later, and `pix_ready` rises after that. The done flag reaches `frame_irq` one cycle after the final chip-select release. The bench polls for that release on rising edges and samples the interrupt at the next falling edge. A flag clear is checked on the falling edge right after the write edge.

// File: rtl/i80_pkg.sv
package i80_pkg;
  localparam int unsigned PH_W = 4;
  localparam logic [2:0] REG_TIMING = 3'd0;
  localparam logic [2:0] REG_TRIG   = 3'd1;
  localparam logic [2:0] REG_SIZE   = 3'd2;
  localparam logic [2:0] REG_IRQEN  = 3'd3;
  localparam logic [2:0] REG_STAT   = 3'd4;

  typedef enum logic [2:0] {PH_IDLE, PH_CSS, PH_WRS, PH_ACT, PH_HLD} phase_e;

  typedef struct packed {
    logic [PH_W-1:0] cs_lead;
    logic [PH_W-1:0] wr_lead;
    logic [PH_W-1:0] wr_low;
    logic [PH_W-1:0] hold;
  } strobe_t;
endpackage

// File: rtl/i80_regs.sv
module i80_regs
  import i80_pkg::*;
#(
  parameter int unsigned DIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  input  logic             frame_done,
  output strobe_t          tim,
  output logic             if_en,
  output logic             trig,
  output logic [DIM_W-1:0] width,
  output logic [DIM_W-1:0] height,
  output logic             irq_en,
  output logic             flag
);
  logic clr_req;
  assign clr_req = cfg_we && (cfg_addr == REG_STAT) && cfg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tim    <= '{cs_lead: '0, wr_lead: '0, wr_low: PH_W'(1), hold: '0};
      if_en  <= 1'b0;
      trig   <= 1'b0;
      width  <= '0;
      height <= '0;
      irq_en <= 1'b0;
      flag   <= 1'b0;
    end else begin
      trig <= cfg_we && (cfg_addr == REG_TRIG) && cfg_wdata[0] && cfg_wdata[1] && if_en;
      if (cfg_we && cfg_addr == REG_TIMING) begin
        tim   <= {cfg_wdata[19:16], cfg_wdata[15:12], cfg_wdata[11:8], cfg_wdata[7:4]};
        if_en <= cfg_wdata[0];
      end
      if (cfg_we && cfg_addr == REG_SIZE) begin
        width  <= cfg_wdata[DIM_W-1:0];
        height <= cfg_wdata[16 +: DIM_W];
      end
      if (cfg_we && cfg_addr == REG_IRQEN) irq_en <= cfg_wdata[0];
      if (frame_done)   flag <= 1'b1;
      else if (clr_req) flag <= 1'b0;
    end
  end

  // R9
  done_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> flag);
  // R10
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !frame_done) |=> !flag);
endmodule

// File: rtl/i80_frame_ctl.sv
module i80_frame_ctl
  import i80_pkg::*;
#(
  parameter int unsigned DIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [DIM_W-1:0] width,
  input  logic [DIM_W-1:0] height,
  input  strobe_t          tim_in,
  input  logic             word_done,
  output logic             busy,
  output strobe_t          tim_q,
  output logic             frame_done
);
  localparam int unsigned CNT_W = 2 * DIM_W;
  logic [CNT_W-1:0] remaining;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      remaining  <= '0;
      frame_done <= 1'b0;
      tim_q      <= '{cs_lead: '0, wr_lead: '0, wr_low: PH_W'(1), hold: '0};
    end else begin
      frame_done <= 1'b0;
      if (trig && !busy) begin
        tim_q <= tim_in;
        if (width == '0 || height == '0) begin
          frame_done <= 1'b1;
        end else begin
          busy      <= 1'b1;
          remaining <= CNT_W'(width) * CNT_W'(height);
        end
      end else if (busy && word_done) begin
        remaining <= remaining - 1'b1;
        if (remaining == CNT_W'(1)) begin
          busy       <= 1'b0;
          frame_done <= 1'b1;
        end
      end
    end
  end

  // R8
  retrig_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trig && !word_done) |=> (busy && $stable(remaining)));
  // R7
  done_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !busy);
endmodule

// File: rtl/i80_strobe.sv
module i80_strobe
  import i80_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  strobe_t       tim,
  input  logic          pix_valid,
  input  logic [DW-1:0] pix_data,
  output logic          pix_ready,
  output logic          cs_n,
  output logic          wr_n,
  output logic [DW-1:0] dout,
  output logic          word_done
);
  phase_e          st, nxt, first;
  logic [PH_W-1:0] cnt, len, low_eff;
  logic            last;

  always_comb begin
    low_eff = (tim.wr_low == '0) ? PH_W'(1) : tim.wr_low;
    case (st)
      PH_CSS:  len = tim.cs_lead;
      PH_WRS:  len = tim.wr_lead;
      PH_ACT:  len = low_eff;
      PH_HLD:  len = tim.hold;
      default: len = PH_W'(1);
    endcase
    case (st)
      PH_CSS:  nxt = (tim.wr_lead != '0) ? PH_WRS : PH_ACT;
      PH_WRS:  nxt = PH_ACT;
      PH_ACT:  nxt = (tim.hold != '0) ? PH_HLD : PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
    if (tim.cs_lead != '0)      first = PH_CSS;
    else if (tim.wr_lead != '0) first = PH_WRS;
    else                        first = PH_ACT;
    last = (st != PH_IDLE) && (cnt == len - PH_W'(1));
  end

  assign word_done = last && (nxt == PH_IDLE);
  assign pix_ready = (st == PH_IDLE) && go;
  assign cs_n      = (st == PH_IDLE);
  assign wr_n      = (st != PH_ACT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= PH_IDLE;
      cnt  <= '0;
      dout <= '0;
    end else if (st == PH_IDLE) begin
      if (go && pix_valid) begin
        dout <= pix_data;
        st   <= first;
        cnt  <= '0;
      end
    end else if (last) begin
      st  <= nxt;
      cnt <= '0;
    end else begin
      cnt <= cnt + PH_W'(1);
    end
  end

  // R3
  strobe_inside_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !cs_n);
  // R4
  data_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$past(cs_n)) |-> $stable(dout));
endmodule

// File: rtl/i80_panel_writer.sv
module i80_panel_writer
  import i80_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned DIM_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic          pix_valid,
  input  logic [DW-1:0] pix_data,
  output logic          pix_ready,
  output logic          lcd_cs_n,
  output logic          lcd_wr_n,
  output logic [DW-1:0] lcd_data,
  output logic          frame_irq
);
  strobe_t          tim_reg, tim_run;
  logic             if_en, trig, irq_en, flag, busy, frame_done, word_done;
  logic [DIM_W-1:0] width, height;

  i80_regs #(.DIM_W(DIM_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frame_done(frame_done), .tim(tim_reg),
    .if_en(if_en), .trig(trig), .width(width), .height(height),
    .irq_en(irq_en), .flag(flag)
  );

  i80_frame_ctl #(.DIM_W(DIM_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .trig(trig), .width(width), .height(height),
    .tim_in(tim_reg), .word_done(word_done), .busy(busy), .tim_q(tim_run),
    .frame_done(frame_done)
  );

  i80_strobe #(.DW(DW)) u_strobe (
    .clk(clk), .rst_n(rst_n), .go(busy), .tim(tim_run),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
    .cs_n(lcd_cs_n), .wr_n(lcd_wr_n), .dout(lcd_data), .word_done(word_done)
  );

  assign frame_irq = flag && irq_en;

  // R5
  ready_only_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> busy);
  // R12
  idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && lcd_cs_n) |=> lcd_cs_n);
endmodule

// File: tb/i80_panel_writer_bench.sv
`timescale 1ns/1ps
module i80_panel_writer_bench;
  localparam int DW = 16;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          pix_valid = 1'b0;
  logic [DW-1:0] pix_data = '0;
  logic          pix_ready, lcd_cs_n, lcd_wr_n, frame_irq;
  logic [DW-1:0] lcd_data;

  int  errs = 0, checks = 0, mon_words = 0, src_idx = 0;
  bit  hs = 0, feed_en = 1, reported = 0;
  int  e_setup = 0, e_act = 1, e_hold = 0;
  int  setup_c = 0, act_c = 0, hold_c = 0;
  bit  seen_wr = 0, prev_cs = 1, prev_wr = 1;

  i80_panel_writer u_i80_panel_writer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_ready(pix_ready), .lcd_cs_n(lcd_cs_n), .lcd_wr_n(lcd_wr_n),
    .lcd_data(lcd_data), .frame_irq(frame_irq)
  );

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] pixval(int i);
    return DW'(i * 945 + 90);
  endfunction

  task automatic chk(bit ok, string tag, int actual, int expected);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  // pixel source: handshake decided at the falling edge, taken at the next rising edge
  always @(negedge clk) begin
    if (hs) src_idx++;
    pix_valid = feed_en && ($urandom_range(0, 3) != 0);
    pix_data  = pixval(src_idx);
    hs        = pix_valid && pix_ready;
  end

  // bus monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (!lcd_cs_n) begin
        if (!lcd_wr_n) begin
          if (prev_wr) begin
            chk(setup_c == e_setup, "R2 lead cycles", setup_c, e_setup);
            chk(lcd_data == pixval(mon_words), "R4 data order", lcd_data, pixval(mon_words));
          end
          act_c++;
          seen_wr = 1;
        end else if (seen_wr) hold_c++;
        else setup_c++;
      end else if (!prev_cs) begin
        chk(act_c == e_act, "R3 strobe low", act_c, e_act);
        chk(hold_c == e_hold, "R4 hold", hold_c, e_hold);
        mon_words++;
        setup_c = 0; act_c = 0; hold_c = 0; seen_wr = 0;
      end
    end
    prev_cs = lcd_cs_n;
    prev_wr = lcd_wr_n;
  end

  task automatic wr_reg(logic [2:0] a, logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_words(int target);
    int g = 0;
    while (mon_words < target && g < 20000) begin
      @(posedge clk);
      g++;
    end
    @(negedge clk);
  endtask

  task automatic setup_frame(int cs, int ws, int act, int hold, int w, int h, bit ien);
    e_setup = cs + ws;
    e_act   = (act == 0) ? 1 : act;
    e_hold  = hold;
    wr_reg(3'd0, (cs << 16) | (ws << 12) | (act << 8) | (hold << 4) | 1);
    wr_reg(3'd2, (h << 16) | w);
    wr_reg(3'd3, {31'd0, ien});
  endtask

  task automatic run_frame(int cs, int ws, int act, int hold, int w, int h, bit ien, string tag);
    int target;
    setup_frame(cs, ws, act, hold, w, h, ien);
    target = mon_words + w * h;
    wr_reg(3'd1, 32'd3);
    wait_words(target);
    chk(frame_irq == ien, "R9 irq at frame end", frame_irq, ien);
    chk(mon_words == target, tag, mon_words, target);
    chk(pix_ready == 1'b0, "R5 ready after frame", pix_ready, 0);
    if (ien) begin
      wr_reg(3'd4, 32'd0);
      chk(frame_irq == 1'b1, "R10 write zero keeps", frame_irq, 1);
    end
    wr_reg(3'd4, 32'd1);
    chk(frame_irq == 1'b0, "R10 clear", frame_irq, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    int base;
    void'($urandom(32'd7717));
    repeat (3) @(negedge clk);
    chk(lcd_cs_n == 1'b1, "R1 cs", lcd_cs_n, 1);
    chk(lcd_wr_n == 1'b1, "R1 wr", lcd_wr_n, 1);
    chk(frame_irq == 1'b0, "R1 irq", frame_irq, 0);
    chk(pix_ready == 1'b0, "R1 ready", pix_ready, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int k = 0; k < 5; k++)
      run_frame($urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15),
                $urandom_range(0, 15), $urandom_range(1, 4), $urandom_range(1, 3), 1'b1,
                "R7 random frame length");
    run_frame(0, 0, 0, 0, 3, 2, 1'b1, "R3 zero timing frame");
    run_frame(15, 15, 15, 15, 1, 1, 1'b1, "R2 max timing frame");

    // R8: repeated triggers during a frame
    setup_frame(2, 1, 2, 1, 3, 2, 1'b1);
    base = mon_words;
    wr_reg(3'd1, 32'd3);
    wait_words(base + 1);
    wr_reg(3'd1, 32'd3);
    wr_reg(3'd1, 32'd3);
    wait_words(base + 6);
    repeat (80) @(negedge clk);
    chk(mon_words == base + 6, "R8 retrigger ignored", mon_words, base + 6);
    wr_reg(3'd4, 32'd1);

    // R11: masked interrupt, then a new trigger is accepted
    run_frame(1, 1, 1, 1, 2, 2, 1'b0, "R11 masked frame");
    base = mon_words;
    run_frame(1, 0, 2, 0, 2, 1, 1'b1, "R11 next trigger accepted");
    chk(mon_words == base + 2, "R11 count", mon_words, base + 2);

    // R5: stalled source keeps the bus idle with ready high
    setup_frame(1, 1, 1, 1, 2, 1, 1'b1);
    feed_en = 0;
    base = mon_words;
    wr_reg(3'd1, 32'd3);
    repeat (30) @(negedge clk);
    chk(lcd_cs_n == 1'b1, "R5 stall cs", lcd_cs_n, 1);
    chk(pix_ready == 1'b1, "R5 stall ready", pix_ready, 1);
    feed_en = 1;
    wait_words(base + 2);
    chk(frame_irq == 1'b1, "R5 stalled frame done", frame_irq, 1);
    wr_reg(3'd4, 32'd1);

    // R6: incomplete trigger writes and disabled interface
    base = mon_words;
    wr_reg(3'd1, 32'd1);
    wr_reg(3'd1, 32'd2);
    repeat (40) @(negedge clk);
    chk(mon_words == base && lcd_cs_n, "R6 partial trigger", mon_words, base);
    wr_reg(3'd0, 32'h0001_1110);
    wr_reg(3'd1, 32'd3);
    repeat (40) @(negedge clk);
    chk(mon_words == base, "R6 disabled interface", mon_words, base);
    chk(frame_irq == 1'b0, "R6 no done", frame_irq, 0);

    // R7: zero geometry
    wr_reg(3'd0, 32'h0001_1111);
    wr_reg(3'd2, 32'h0000_0005);
    wr_reg(3'd1, 32'd3);
    repeat (4) @(negedge clk);
    chk(frame_irq == 1'b1, "R7 zero size done", frame_irq, 1);
    chk(mon_words == base, "R7 zero size words", mon_words, base);
    wr_reg(3'd4, 32'd1);

    // R12: no activity without a trigger
    repeat (100) @(negedge clk);
    chk(mon_words == base && lcd_cs_n, "R12 idle bus", mon_words, base);
    report();
  end
endmodule